// File: doc/BRIEF.md
# Dual-Register Input Capture Unit

This block timestamps external events. A free-running 16-bit counter advances on every clock. Two capture registers each take a snapshot of that counter when a qualified edge arrives on an asynchronous trigger pin. Slot 0 always listens to trigger 0. Slot 1 listens to trigger 0 or to trigger 1, as chosen by a select input. Each trigger has its own two-bit edge qualifier. The qualifier can be off, or it can fire on the rising edge, the falling edge or both edges.

When a single edge is selected, the difference between two successive snapshots gives the period of the input. When both edges are selected, the difference between consecutive snapshots gives the high time or the low time. Each slot can also be placed in hold mode. In hold mode the slot ignores its trigger and keeps its stored value. A one-cycle event pulse marks every load. An asynchronous active-low reset and a synchronous clear both return the block to zero.

Top module: `cap_unit_dual`

## Requirements
- R1: `count_o` increases by one on every clock edge while neither reset nor clear is active, and it wraps from 16'hFFFF to 16'h0000.
- R2: While `rst_n` is low, or one clock after `sclr` is sampled high, the counter, both slot values and both event outputs are zero.
- R3: A trigger change made between two clock edges is first sampled by a two-flop synchronizer. The slot then loads the counter value present before the third rising edge after the change. If `count_o` reads C just after the change, the value stored is C+2 modulo 2^16.
- R4: Slot 1 follows trigger 0 when `slot1_src_sel` is 0 and follows trigger 1 when it is 1. The trigger that is not selected has no effect on slot 1.
- R5: The edge code for each trigger is: 2'b00 never fires, 2'b01 fires on low-to-high, 2'b10 fires on high-to-low, and 2'b11 fires on either change.
- R6: When a slot's capture enable is 0, that slot ignores every trigger edge. It raises no event and its value is unchanged.
- R7: A slot's event output is high for exactly one clock, in the cycle in which its new value first appears, and it is high only after a load.
- R8: With `slot1_src_sel` at 0 and both slots enabled, one qualified edge on trigger 0 loads both slots in the same cycle with the same value.
- R9: The two triggers are qualified independently, each by its own edge code, even when both change in the same cycle.
- R10: With code 2'b11, the difference between two consecutive captures equals the number of clocks between the two input changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with clk |
| sclr | input | 1 | Synchronous clear of the counter, both slots and the edge history |
| trig0_i | input | 1 | Asynchronous trigger 0 |
| trig1_i | input | 1 | Asynchronous trigger 1 |
| trig0_mode | input | 2 | Edge code for trigger 0 |
| trig1_mode | input | 2 | Edge code for trigger 1 |
| slot0_cap_en | input | 1 | 1: slot 0 captures; 0: slot 0 holds |
| slot1_cap_en | input | 1 | 1: slot 1 captures; 0: slot 1 holds |
| slot1_src_sel | input | 1 | Slot 1 trigger source: 0 selects trigger 0, 1 selects trigger 1 |
| count_o | output | 16 | Free-running counter value |
| slot0_val_o | output | 16 | Slot 0 stored value |
| slot1_val_o | output | 16 | Slot 1 stored value |
| slot0_evt_o | output | 1 | One-cycle pulse when slot 0 loads |
| slot1_evt_o | output | 1 | One-cycle pulse when slot 1 loads |

## Verification
Slot 0 and slot 1 can load in the same cycle. This happens either through one shared edge on trigger 0 with slot 1 following that trigger, or through both triggers changing together with slot 1 following trigger 1. The bench provokes both cases. For each edge the driver queues one item per slot that should load. The monitor expects both event pulses in the same cycle and checks each slot's value against its own queued item. A capture across the counter wrap is also provoked, and the captured value must be 16'h0000.

// File: rtl/cap_unit_pkg.sv
package cap_unit_pkg;

  localparam int unsigned NUM_TRIG = 2;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_mode_e;

endpackage

// File: rtl/cap_trig_qual.sv
module cap_trig_qual
  import cap_unit_pkg::*;
#(
  parameter int unsigned STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sclr,
  input  logic       trig_async,
  input  edge_mode_e mode,
  output logic       hit
);

  localparam int unsigned MSB = STAGES - 1;

  logic [STAGES-1:0] sync_q, sync_d;
  logic              prev_q, prev_d;
  logic              rise, fall;

  // next-state
  always_comb begin
    if (sclr) begin
      sync_d = '0;
      prev_d = 1'b0;
    end else begin
      sync_d = {sync_q[STAGES-2:0], trig_async};
      prev_d = sync_q[MSB];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign rise = sync_q[MSB] & ~prev_q;
  assign fall = ~sync_q[MSB] & prev_q;

  always_comb begin
    case (mode)
      EDGE_RISE: hit = rise;
      EDGE_FALL: hit = fall;
      EDGE_BOTH: hit = rise | fall;
      default:   hit = 1'b0;
    endcase
  end

  // R5
  off_mode_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == EDGE_OFF) |-> !hit);

  // R5
  rise_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && mode == EDGE_RISE) |-> (sync_q[MSB] && !prev_q));

endmodule

// File: rtl/cap_counter.sv
module cap_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sclr,
  output logic [W-1:0] count
);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (sclr) cnt_d = '0;
    else      cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign count = cnt_q;

  // R1
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sclr |=> (cnt_q == $past(cnt_q) + W'(1)));

  // R2
  cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sclr |=> (cnt_q == '0));

endmodule

// File: rtl/cap_slot.sv
module cap_slot #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sclr,
  input  logic         cap_en,
  input  logic         trig_hit,
  input  logic [W-1:0] count,
  output logic [W-1:0] value,
  output logic         evt
);

  logic [W-1:0] val_q, val_d;
  logic         evt_q, evt_d;
  logic         load;

  assign load = cap_en & trig_hit;

  always_comb begin
    val_d = val_q;
    evt_d = 1'b0;
    if (sclr) begin
      val_d = '0;
    end else if (load) begin
      val_d = count;
      evt_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= '0;
      evt_q <= 1'b0;
    end else begin
      val_q <= val_d;
      evt_q <= evt_d;
    end
  end

  assign value = val_q;
  assign evt   = evt_q;

  // R6
  hold_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sclr && !cap_en) |=> (!evt_q && val_q == $past(val_q)));

  // R7
  evt_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_q |-> (val_q == $past(count)));

  // R7
  no_evt_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sclr && !trig_hit) |=> (!evt_q && $stable(val_q)));

endmodule

// File: rtl/cap_unit_dual.sv
module cap_unit_dual
  import cap_unit_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sclr,
  input  logic             trig0_i,
  input  logic             trig1_i,
  input  logic [1:0]       trig0_mode,
  input  logic [1:0]       trig1_mode,
  input  logic             slot0_cap_en,
  input  logic             slot1_cap_en,
  input  logic             slot1_src_sel,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] slot0_val_o,
  output logic [CNT_W-1:0] slot1_val_o,
  output logic             slot0_evt_o,
  output logic             slot1_evt_o
);

  logic [NUM_TRIG-1:0] trig_raw;
  logic [NUM_TRIG-1:0] trig_hit;
  logic [1:0]          mode_raw [NUM_TRIG];
  logic [CNT_W-1:0]    cnt;
  logic                slot1_hit;

  assign trig_raw    = {trig1_i, trig0_i};
  assign mode_raw[0] = trig0_mode;
  assign mode_raw[1] = trig1_mode;

  cap_counter #(.W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .sclr  (sclr),
    .count (cnt)
  );

  for (genvar g = 0; g < NUM_TRIG; g++) begin : g_qual
    cap_trig_qual #(.STAGES(SYNC_STAGES)) u_qual (
      .clk        (clk),
      .rst_n      (rst_n),
      .sclr       (sclr),
      .trig_async (trig_raw[g]),
      .mode       (edge_mode_e'(mode_raw[g])),
      .hit        (trig_hit[g])
    );
  end

  assign slot1_hit = slot1_src_sel ? trig_hit[1] : trig_hit[0];

  cap_slot #(.W(CNT_W)) u_slot0 (
    .clk      (clk),
    .rst_n    (rst_n),
    .sclr     (sclr),
    .cap_en   (slot0_cap_en),
    .trig_hit (trig_hit[0]),
    .count    (cnt),
    .value    (slot0_val_o),
    .evt      (slot0_evt_o)
  );

  cap_slot #(.W(CNT_W)) u_slot1 (
    .clk      (clk),
    .rst_n    (rst_n),
    .sclr     (sclr),
    .cap_en   (slot1_cap_en),
    .trig_hit (slot1_hit),
    .count    (cnt),
    .value    (slot1_val_o),
    .evt      (slot1_evt_o)
  );

  assign count_o = cnt;

  // R8
  shared_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sclr && !slot1_src_sel && slot0_cap_en && slot1_cap_en && trig_hit[0])
    |=> (slot0_evt_o && slot1_evt_o && slot0_val_o == slot1_val_o));

  // R4
  src_isolation_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sclr && slot1_src_sel && !trig_hit[1]) |=> !slot1_evt_o);

  // R4
  src_zero_isolation_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sclr && !slot1_src_sel && !trig_hit[0]) |=> !slot1_evt_o);

endmodule

// File: tb/cap_unit_dual_tb_top.sv
module cap_unit_dual_tb_top;

  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        s;
    logic [15:0] v;
  } exp_t;

  logic        clk;
  logic        rst_n;
  logic        sclr;
  logic        trig0_i, trig1_i;
  logic [1:0]  trig0_mode, trig1_mode;
  logic        slot0_cap_en, slot1_cap_en, slot1_src_sel;
  logic [15:0] count_o, slot0_val_o, slot1_val_o;
  logic        slot0_evt_o, slot1_evt_o;

  int          n_checks = 0;
  int          n_errors = 0;
  exp_t        q[$];
  logic [15:0] mdl_v0 = 16'd0, mdl_v1 = 16'd0, prev_v0 = 16'd0;
  logic [15:0] last_cnt = 16'd0;
  bit          rst_prev = 1'b0;

  cap_unit_dual dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .sclr          (sclr),
    .trig0_i       (trig0_i),
    .trig1_i       (trig1_i),
    .trig0_mode    (trig0_mode),
    .trig1_mode    (trig1_mode),
    .slot0_cap_en  (slot0_cap_en),
    .slot1_cap_en  (slot1_cap_en),
    .slot1_src_sel (slot1_src_sel),
    .count_o       (count_o),
    .slot0_val_o   (slot0_val_o),
    .slot1_val_o   (slot1_val_o),
    .slot0_evt_o   (slot0_evt_o),
    .slot1_evt_o   (slot1_evt_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit qual(input logic [1:0] m, input logic o, input logic n);
    case (m)
      2'b01:   return (!o && n);
      2'b10:   return (o && !n);
      2'b11:   return (o != n);
      default: return 1'b0;
    endcase
  endfunction

  // monitor: pops expected items as events appear
  task automatic take_evt(input logic s, input logic [15:0] v);
    exp_t e;
    if (q.size() == 0) begin
      check(1'b0, "R7 unexpected event", {15'd0, s, v}, 32'd0);
    end else begin
      e = q.pop_front();
      check(e.s == s && e.v === v, "R3 captured value", {15'd0, s, v}, {15'd0, e.s, e.v});
    end
    if (s == 1'b0) begin
      prev_v0 = mdl_v0;
      mdl_v0  = v;
    end else begin
      mdl_v1 = v;
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      rst_prev = 1'b0;
    end else begin
      if (rst_prev)
        check(count_o === (sclr ? 16'd0 : last_cnt + 16'd1), "R1 counter step",
              {16'd0, count_o}, {16'd0, (sclr ? 16'd0 : last_cnt + 16'd1)});
      if (slot0_evt_o) take_evt(1'b0, slot0_val_o);
      if (slot1_evt_o) take_evt(1'b1, slot1_val_o);
      last_cnt = count_o;
      rst_prev = 1'b1;
    end
  end

  // driver: changes triggers and queues predicted loads
  task automatic drive(input logic n0, input logic n1);
    logic [15:0] c;
    bit          h0, h1;
    @(negedge clk);
    #1;
    c  = count_o;
    h0 = qual(trig0_mode, trig0_i, n0);
    h1 = qual(trig1_mode, trig1_i, n1);
    if (slot0_cap_en && h0) q.push_back(exp_t'({1'b0, c + 16'd2}));
    if (slot1_cap_en && (slot1_src_sel ? h1 : h0)) q.push_back(exp_t'({1'b1, c + 16'd2}));
    trig0_i = n0;
    trig1_i = n1;
  endtask

  task automatic settle(input string tag);
    repeat (6) @(negedge clk);
    check(q.size() == 0, tag, q.size(), 32'd0);
    check(slot0_val_o === mdl_v0, tag, {16'd0, slot0_val_o}, {16'd0, mdl_v0});
    check(slot1_val_o === mdl_v1, tag, {16'd0, slot1_val_o}, {16'd0, mdl_v1});
  endtask

  task automatic cfg(input logic [1:0] m0, input logic [1:0] m1,
                     input logic e0, input logic e1, input logic src);
    @(negedge clk);
    #1;
    trig0_mode    = m0;
    trig1_mode    = m1;
    slot0_cap_en  = e0;
    slot1_cap_en  = e1;
    slot1_src_sel = src;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
    $finish;
  end

  initial begin
    rst_n = 1'b0; sclr = 1'b0; trig0_i = 1'b0; trig1_i = 1'b0;
    trig0_mode = 2'b00; trig1_mode = 2'b00;
    slot0_cap_en = 1'b0; slot1_cap_en = 1'b0; slot1_src_sel = 1'b0;
    repeat (3) @(negedge clk);
    // R2 reset state
    check(count_o === 16'd0 && slot0_val_o === 16'd0 && slot1_val_o === 16'd0,
          "R2 reset values", {16'd0, count_o}, 32'd0);
    check(!slot0_evt_o && !slot1_evt_o, "R2 reset events", {30'd0, slot0_evt_o, slot1_evt_o}, 32'd0);
    #1 rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R3 R5 rising on trigger 0
    cfg(2'b01, 2'b00, 1'b1, 1'b0, 1'b0);
    drive(1'b1, 1'b0);
    settle("R3 rising capture");
    // R5 falling edge ignored in rising mode
    drive(1'b0, 1'b0);
    settle("R5 falling ignored");
    // R5 falling mode
    cfg(2'b10, 2'b00, 1'b1, 1'b0, 1'b0);
    drive(1'b1, 1'b0);
    settle("R5 rise ignored in fall mode");
    drive(1'b0, 1'b0);
    settle("R5 falling capture");
    // R5 off mode
    cfg(2'b00, 2'b00, 1'b1, 1'b1, 1'b0);
    drive(1'b1, 1'b0);
    settle("R5 off mode rise");
    drive(1'b0, 1'b0);
    settle("R5 off mode fall");

    // R10 pulse width with both edges
    cfg(2'b11, 2'b00, 1'b1, 1'b0, 1'b0);
    drive(1'b1, 1'b0);
    repeat (8) @(negedge clk);
    drive(1'b0, 1'b0);
    settle("R10 both-edge captures");
    check(mdl_v0 - prev_v0 == 16'd9, "R10 pulse width", {16'd0, mdl_v0 - prev_v0}, 32'd9);

    // R8 both slots on one trigger 0 edge
    cfg(2'b01, 2'b00, 1'b1, 1'b1, 1'b0);
    drive(1'b1, 1'b0);
    settle("R8 shared edge");
    check(slot0_val_o === slot1_val_o, "R8 equal values", {16'd0, slot1_val_o}, {16'd0, slot0_val_o});

    // R4 slot 1 follows trigger 1, ignores trigger 0
    cfg(2'b10, 2'b01, 1'b1, 1'b1, 1'b1);
    drive(1'b0, 1'b0);
    settle("R4 trigger 0 edge ignored by slot 1");
    drive(1'b0, 1'b1);
    settle("R4 trigger 1 capture");
    // R4 slot 1 on trigger 0 ignores trigger 1
    cfg(2'b01, 2'b11, 1'b1, 1'b1, 1'b0);
    drive(1'b0, 1'b0);
    settle("R4 trigger 1 ignored when source is 0");

    // R9 both triggers change together, independent codes
    cfg(2'b01, 2'b10, 1'b1, 1'b1, 1'b1);
    drive(1'b1, 1'b1);
    settle("R9 rise only on trigger 0");
    drive(1'b0, 1'b0);
    settle("R9 fall only on trigger 1");
    cfg(2'b11, 2'b11, 1'b1, 1'b1, 1'b1);
    drive(1'b1, 1'b1);
    settle("R9 simultaneous both-edge");
    check(slot0_val_o === slot1_val_o, "R9 same-cycle values", {16'd0, slot1_val_o}, {16'd0, slot0_val_o});

    // R6 hold mode on slot 0, slot 1 still capturing from trigger 0
    cfg(2'b11, 2'b00, 1'b0, 1'b1, 1'b0);
    drive(1'b0, 1'b1);
    settle("R6 slot 0 hold");
    cfg(2'b11, 2'b11, 1'b0, 1'b0, 1'b1);
    drive(1'b1, 1'b0);
    settle("R6 both slots hold");

    // R2 synchronous clear
    cfg(2'b00, 2'b00, 1'b0, 1'b0, 1'b0);
    drive(1'b0, 1'b0);
    repeat (4) @(negedge clk);
    #1 sclr = 1'b1;
    @(negedge clk);
    check(count_o === 16'd0 && slot0_val_o === 16'd0 && slot1_val_o === 16'd0,
          "R2 sync clear", {16'd0, slot0_val_o | slot1_val_o | count_o}, 32'd0);
    #1 sclr = 1'b0;
    mdl_v0 = 16'd0;
    mdl_v1 = 16'd0;

    // R1 capture across wrap
    cfg(2'b01, 2'b00, 1'b1, 1'b0, 1'b0);
    while (count_o !== 16'hFFFD) @(negedge clk);
    drive(1'b1, 1'b0);
    settle("R1 wrap capture");
    check(slot0_val_o === 16'h0000, "R1 wrapped value", {16'd0, slot0_val_o}, 32'd0);

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule